// File: doc/BRIEF.md
# Dual-Channel UART Host Register Front-End

This block sits between an 8-bit asynchronous host bus and two UART channels. The bus has an active-low select, separate active-low read and write strobes, three address lines and one channel-select pin. The block decodes each access and steers it to one of two identical register banks. Each bank holds a line-control byte, the two divisor bytes and an alternate-function byte. Any address the bank does not own goes to the channel core through a one-cycle write strobe and a read-data return path. The FIFOs, the baud generator and the serial engines stay outside the block.

The write strobe and the chip select are brought into the internal clock domain through a synchronizer chain. A write is committed once, after the write strobe returns high. Read data is combinational and is driven only while select and read strobe are both low. When both divisor bytes of a channel are zero, a read of either divisor address returns a fixed identification byte or revision byte instead of the stored value. Each channel also drives a multifunction pin, and its alternate-function byte chooses what appears on that pin.

Top module: `duart_host_regif`

## Requirements
- R1: While `bus_cs_n` is high, a write strobe changes no register and causes no core write, and `bus_rdata_oe` stays 0.
- R2: `bus_chsel` = 0 routes an access to channel A and 1 routes it to channel B. A write to one channel leaves every register of the other channel unchanged, and at most one core write strobe is high in any cycle.
- R3: Address 3 is the line-control byte of the selected channel, readable and writable in every mode. Its bit 7 is the divisor-access bit.
- R4: With divisor access set, addresses 0, 1 and 2 reach the divisor low byte, the divisor high byte and the alternate-function byte. With it clear, those addresses go to the core: a write gives one `core_wr_stb` pulse carrying the address and data, and a read returns the channel's core read data. Addresses 4 to 7 always go to the core.
- R5: With divisor access set and both divisor bytes 0x00, a read of address 1 returns the identification byte 0x06.
- R6: Under the same condition, a read of address 0 returns the revision byte 0x01.
- R7: If either divisor byte is nonzero, reads of addresses 0 and 1 return the stored bytes. Writes always store the byte written, zero included.
- R8: The alternate-function byte at address 2 reads back as written and keeps its value through core writes to address 2.
- R9: Alternate-function bits [2:1] select the channel's `mf_out`: 00 gives `aux_out_n`, 01 gives `baud_clk`, 10 gives the inverse of `rx_ready`, and 11 gives a constant high.
- R10: A write commits only after the write strobe rises. While the strobe is held low the target register keeps its old value, and each strobe produces exactly one commit.
- R11: Reset (`rst` high) clears every bank register of both channels to 0x00, so each `mf_out` follows `aux_out_n`.
- R12: `bus_rdata_oe` is high only while `bus_cs_n` and `bus_rd_n` are both low, and `bus_rdata` is 0x00 whenever `bus_rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock |
| rst | input | 1 | active-high reset |
| bus_cs_n | input | 1 | active-low chip select |
| bus_rd_n | input | 1 | active-low read strobe |
| bus_wr_n | input | 1 | active-low write strobe |
| bus_chsel | input | 1 | channel select, 0 = A, 1 = B |
| bus_addr | input | 3 | register address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, zero when not driven |
| bus_rdata_oe | output | 1 | read data valid / drive enable |
| core_rdata_a | input | 8 | channel A core read data |
| core_rdata_b | input | 8 | channel B core read data |
| core_wr_stb | output | 2 | per-channel core write pulse, bit 0 = A |
| core_addr | output | 3 | address of a core write |
| core_wdata | output | 8 | data of a core write |
| aux_out_n | input | 2 | per-channel auxiliary output level |
| rx_ready | input | 2 | per-channel receive-ready status |
| baud_clk | input | 2 | per-channel baud clock |
| mf_out | output | 2 | per-channel multifunction pin |

## Verification
The assertions assume that address, data and channel select are steady for the whole time the write strobe is low. They also assume that each strobe is held low for more cycles than the synchronizer depth, so one strobe is never split into two commits or missed. The bench changes those inputs only on the falling clock edge and only while both strobes are high, and it holds each strobe low for four clock cycles. Read checks sample the combinational read path in the middle of the clock period, and the bench never performs a read and a write together except in the deliberate check that a held write strobe has not yet committed.

// File: rtl/duart_hif_pkg.sv
package duart_hif_pkg;
   localparam int unsigned HIF_DW = 8;
   localparam int unsigned HIF_AW = 3;

   typedef logic [HIF_DW-1:0] hif_byte_t;
   typedef logic [HIF_AW-1:0] hif_addr_t;

   // bank offsets; divisor/alt-function only while divisor access is set
   localparam hif_addr_t OFS_DIV_LO = 3'd0;
   localparam hif_addr_t OFS_DIV_HI = 3'd1;
   localparam hif_addr_t OFS_ALTFN  = 3'd2;
   localparam hif_addr_t OFS_LINE   = 3'd3;
   localparam int unsigned DIV_ACCESS_BIT = 7;

   typedef enum logic [1:0] {
      MF_AUX   = 2'b00,
      MF_BAUD  = 2'b01,
      MF_RXRDY = 2'b10,
      MF_IDLE  = 2'b11
   } mf_sel_e;

   typedef struct packed {
      hif_byte_t line;
      hif_byte_t div_lo;
      hif_byte_t div_hi;
      hif_byte_t altfn;
   } chan_bank_t;

   typedef struct packed {
      logic      vld;
      logic      ch;
      hif_addr_t addr;
      hif_byte_t data;
   } bus_wr_t;
endpackage

// File: rtl/hif_wr_capture.sv
module hif_wr_capture
   import duart_hif_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      cs_n,
   input  logic      wr_n,
   input  logic      chsel,
   input  hif_addr_t addr,
   input  hif_byte_t wdata,
   output bus_wr_t   commit
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("hif_wr_capture: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] cs_sync;
   logic [SYNC_STAGES-1:0] wr_sync;
   logic                   wr_last;
   logic                   hold_vld;
   logic                   hold_ch;
   hif_addr_t              hold_addr;
   hif_byte_t              hold_data;
   logic                   strobe_low;
   logic                   strobe_rise;

   always_comb begin
      strobe_low  = ~cs_sync[SYNC_STAGES-1] & ~wr_sync[SYNC_STAGES-1];
      strobe_rise = wr_sync[SYNC_STAGES-1] & ~wr_last;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_sync <= '1;
         wr_sync <= '1;
         wr_last <= 1'b1;
      end else begin
         cs_sync <= {cs_sync[SYNC_STAGES-2:0], cs_n};
         wr_sync <= {wr_sync[SYNC_STAGES-2:0], wr_n};
         wr_last <= wr_sync[SYNC_STAGES-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_vld  <= 1'b0;
         hold_ch   <= 1'b0;
         hold_addr <= '0;
         hold_data <= '0;
      end else if (strobe_low) begin
         hold_vld  <= 1'b1;
         hold_ch   <= chsel;
         hold_addr <= addr;
         hold_data <= wdata;
      end else if (strobe_rise) begin
         hold_vld  <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         commit <= '0;
      end else begin
         commit.vld  <= strobe_rise & hold_vld;
         commit.ch   <= hold_ch;
         commit.addr <= hold_addr;
         commit.data <= hold_data;
      end
   end

   // R10
   single_commit_chk: assert property (@(posedge clk) disable iff (rst)
      commit.vld |=> !commit.vld);
endmodule

// File: rtl/hif_chan_bank.sv
module hif_chan_bank
   import duart_hif_pkg::*;
#(
   parameter hif_byte_t DEV_ID = 8'h06,
   parameter hif_byte_t REV_ID = 8'h01
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  hif_addr_t  wr_addr,
   input  hif_byte_t  wr_data,
   input  hif_addr_t  rd_addr,
   input  hif_byte_t  core_rdata,
   output chan_bank_t bank,
   output hif_byte_t  rd_data,
   output logic       core_wr
);
   logic div_access;
   logic hit_line;
   logic hit_lo;
   logic hit_hi;
   logic hit_alt;
   logic div_blank;

   always_comb begin
      div_access = bank.line[DIV_ACCESS_BIT];
      hit_line   = (wr_addr == OFS_LINE);
      hit_lo     = div_access & (wr_addr == OFS_DIV_LO);
      hit_hi     = div_access & (wr_addr == OFS_DIV_HI);
      hit_alt    = div_access & (wr_addr == OFS_ALTFN);
      core_wr    = wr_en & ~(hit_line | hit_lo | hit_hi | hit_alt);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bank <= '0;
      end else if (wr_en) begin
         if (hit_line) bank.line   <= wr_data;
         if (hit_lo)   bank.div_lo <= wr_data;
         if (hit_hi)   bank.div_hi <= wr_data;
         if (hit_alt)  bank.altfn  <= wr_data;
      end
   end

   // identification substitution is a read-path effect only
   always_comb begin
      div_blank = (bank.div_lo == '0) && (bank.div_hi == '0);
      rd_data   = core_rdata;
      if (rd_addr == OFS_LINE) begin
         rd_data = bank.line;
      end else if (div_access) begin
         case (rd_addr)
            OFS_DIV_LO: rd_data = div_blank ? REV_ID : bank.div_lo;
            OFS_DIV_HI: rd_data = div_blank ? DEV_ID : bank.div_hi;
            OFS_ALTFN:  rd_data = bank.altfn;
            default:    rd_data = core_rdata;
         endcase
      end
   end

   // R10
   bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(bank));

   // R4
   core_excl_chk: assert property (@(posedge clk) disable iff (rst)
      core_wr |=> $stable(bank));
endmodule

// File: rtl/hif_mf_select.sv
module hif_mf_select
   import duart_hif_pkg::*;
#(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  mf_sel_e sel,
   input  logic    aux_n,
   input  logic    rx_rdy,
   input  logic    baud,
   output logic    mf
);
   always_comb begin
      unique case (sel)
         MF_AUX:   mf = aux_n;
         MF_BAUD:  mf = baud;
         MF_RXRDY: mf = ~rx_rdy;
         default:  mf = IDLE_LEVEL;
      endcase
   end
endmodule

// File: rtl/duart_host_regif.sv
module duart_host_regif
   import duart_hif_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  DEV_ID      = 8'h06,
   parameter logic [7:0]  REV_ID      = 8'h01,
   parameter logic        MF_IDLE_LVL = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_cs_n,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   input  logic              bus_chsel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rdata_oe,
   input  logic [DATA_W-1:0] core_rdata_a,
   input  logic [DATA_W-1:0] core_rdata_b,
   output logic [1:0]        core_wr_stb,
   output logic [ADDR_W-1:0] core_addr,
   output logic [DATA_W-1:0] core_wdata,
   input  logic [1:0]        aux_out_n,
   input  logic [1:0]        rx_ready,
   input  logic [1:0]        baud_clk,
   output logic [1:0]        mf_out
);
   localparam int unsigned NUM_CH = 2;

   generate
      if (DATA_W != HIF_DW) begin : g_bad_dw
         $error("duart_host_regif: DATA_W must equal the package byte width");
      end
      if (ADDR_W != HIF_AW) begin : g_bad_aw
         $error("duart_host_regif: ADDR_W must equal the package address width");
      end
   endgenerate

   bus_wr_t    commit;
   chan_bank_t bank_q   [NUM_CH];
   hif_byte_t  ch_rdata [NUM_CH];
   hif_byte_t  core_rd  [NUM_CH];
   logic [NUM_CH-1:0] bank_we;

   assign core_rd[0] = core_rdata_a;
   assign core_rd[1] = core_rdata_b;

   hif_wr_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
      .clk    (clk),
      .rst    (rst),
      .cs_n   (bus_cs_n),
      .wr_n   (bus_wr_n),
      .chsel  (bus_chsel),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .commit (commit)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      assign bank_we[g] = commit.vld & (commit.ch == 1'(g));

      hif_chan_bank #(.DEV_ID(DEV_ID), .REV_ID(REV_ID)) u_bank (
         .clk        (clk),
         .rst        (rst),
         .wr_en      (bank_we[g]),
         .wr_addr    (commit.addr),
         .wr_data    (commit.data),
         .rd_addr    (bus_addr),
         .core_rdata (core_rd[g]),
         .bank       (bank_q[g]),
         .rd_data    (ch_rdata[g]),
         .core_wr    (core_wr_stb[g])
      );

      hif_mf_select #(.IDLE_LEVEL(MF_IDLE_LVL)) u_mf (
         .sel    (mf_sel_e'(bank_q[g].altfn[2:1])),
         .aux_n  (aux_out_n[g]),
         .rx_rdy (rx_ready[g]),
         .baud   (baud_clk[g]),
         .mf     (mf_out[g])
      );
   end

   always_comb begin
      bus_rdata_oe = ~bus_cs_n & ~bus_rd_n;
      bus_rdata    = bus_rdata_oe ? ch_rdata[bus_chsel] : '0;
      core_addr    = commit.addr;
      core_wdata   = commit.data;
   end

   // R2
   lane_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(core_wr_stb));

   // R2
   iso_a_to_b_chk: assert property (@(posedge clk) disable iff (rst)
      bank_we[0] |=> $stable(bank_q[1]));

   // R2
   iso_b_to_a_chk: assert property (@(posedge clk) disable iff (rst)
      bank_we[1] |=> $stable(bank_q[0]));

   // R12
   idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
      !bus_rdata_oe |-> (bus_rdata == '0));
endmodule

// File: tb/duart_host_regif_bench.sv
module duart_host_regif_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_chsel = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_rdata_oe;
   logic [7:0] core_rdata_a = 8'h5A, core_rdata_b = 8'hA5;
   logic [1:0] core_wr_stb;
   logic [2:0] core_addr;
   logic [7:0] core_wdata;
   logic [1:0] aux_out_n = 2'b10, rx_ready = 2'b00, baud_clk = 2'b00;
   logic [1:0] mf_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [11:0] exp_q [$];

   always #2 clk = ~clk;

   duart_host_regif u_duart_host_regif (
      .clk, .rst, .bus_cs_n, .bus_rd_n, .bus_wr_n, .bus_chsel, .bus_addr,
      .bus_wdata, .bus_rdata, .bus_rdata_oe, .core_rdata_a, .core_rdata_b,
      .core_wr_stb, .core_addr, .core_wdata, .aux_out_n, .rx_ready,
      .baud_clk, .mf_out
   );

   task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   // scoreboard monitor for core writes (R4, R10)
   always @(negedge clk) begin
      if (!rst && core_wr_stb != 2'b00) begin
         if (exp_q.size() == 0) begin
            chk("R4 unexpected core write", {core_wr_stb[1], core_addr, core_wdata}, 12'hFFF);
         end else begin
            chk("R4 core write", {core_wr_stb[1], core_addr, core_wdata}, exp_q.pop_front());
         end
      end
   end

   task automatic bus_write(input logic ch, input logic [2:0] a, input logic [7:0] d,
                            input logic to_core, input logic sel_on = 1'b1);
      @(negedge clk);
      bus_chsel = ch; bus_addr = a; bus_wdata = d; bus_cs_n = ~sel_on;
      @(negedge clk);
      bus_wr_n = 1'b0;
      repeat (4) @(negedge clk);
      bus_wr_n = 1'b1;
      if (to_core) exp_q.push_back({ch, a, d});
      repeat (2) @(negedge clk);
      bus_cs_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic bus_read(input logic ch, input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_chsel = ch; bus_addr = a; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd_n = 1'b1; bus_cs_n = 1'b1;
   endtask

   task automatic rd_chk(input string req, input logic ch, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] v;
      bus_read(ch, a, v);
      chk(req, {4'h0, v}, {4'h0, exp});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11 reset state
      chk("R11 mf follows aux after reset", {10'h0, mf_out}, {10'h0, aux_out_n});
      rd_chk("R11 line A reset", 1'b0, 3'd3, 8'h00);
      rd_chk("R11 line B reset", 1'b1, 3'd3, 8'h00);
      #1 chk("R12 idle oe", {11'h0, bus_rdata_oe}, 12'h0);
      chk("R12 idle data", {4'h0, bus_rdata}, 12'h0);

      // R3, R5, R6
      bus_write(1'b0, 3'd3, 8'h80, 1'b0);
      rd_chk("R3 line A readback", 1'b0, 3'd3, 8'h80);
      rd_chk("R5 id byte", 1'b0, 3'd1, 8'h06);
      rd_chk("R6 revision byte", 1'b0, 3'd0, 8'h01);

      // R7
      bus_write(1'b0, 3'd0, 8'h0C, 1'b0);
      rd_chk("R7 div lo stored", 1'b0, 3'd0, 8'h0C);
      rd_chk("R7 div hi stored zero", 1'b0, 3'd1, 8'h00);
      bus_write(1'b0, 3'd1, 8'h05, 1'b0);
      bus_write(1'b0, 3'd0, 8'h00, 1'b0);
      rd_chk("R7 div lo zero stored", 1'b0, 3'd0, 8'h00);
      rd_chk("R7 div hi stored", 1'b0, 3'd1, 8'h05);
      bus_write(1'b0, 3'd1, 8'h00, 1'b0);
      rd_chk("R5 id again after zero write", 1'b0, 3'd1, 8'h06);

      // R2 isolation
      bus_write(1'b1, 3'd3, 8'h80, 1'b0);
      rd_chk("R2 B id untouched by A writes", 1'b1, 3'd1, 8'h06);
      bus_write(1'b1, 3'd0, 8'h33, 1'b0);
      rd_chk("R2 B div lo", 1'b1, 3'd0, 8'h33);
      rd_chk("R2 A div lo unchanged", 1'b0, 3'd0, 8'h01);
      bus_write(1'b0, 3'd2, 8'h06, 1'b0);
      rd_chk("R2 B altfn unchanged", 1'b1, 3'd2, 8'h00);
      rd_chk("R2 B line unchanged", 1'b1, 3'd3, 8'h80);

      // R9 multifunction selection, channel A
      @(negedge clk);
      chk("R9 sel 11 high", {11'h0, mf_out[0]}, 12'h1);
      bus_write(1'b0, 3'd2, 8'h04, 1'b0);
      rx_ready[0] = 1'b1; #1;
      chk("R9 rxrdy inverted (1)", {11'h0, mf_out[0]}, 12'h0);
      rx_ready[0] = 1'b0; #1;
      chk("R9 rxrdy inverted (0)", {11'h0, mf_out[0]}, 12'h1);
      bus_write(1'b0, 3'd2, 8'h02, 1'b0);
      baud_clk[0] = 1'b1; #1;
      chk("R9 baud (1)", {11'h0, mf_out[0]}, 12'h1);
      baud_clk[0] = 1'b0; #1;
      chk("R9 baud (0)", {11'h0, mf_out[0]}, 12'h0);
      bus_write(1'b0, 3'd2, 8'h09, 1'b0);
      aux_out_n[0] = 1'b1; #1;
      chk("R9 aux (1)", {11'h0, mf_out[0]}, 12'h1);
      aux_out_n[0] = 1'b0; #1;
      chk("R9 aux (0)", {11'h0, mf_out[0]}, 12'h0);
      chk("R9 B still aux", {11'h0, mf_out[1]}, {11'h0, aux_out_n[1]});

      // R4, R8 core routing with divisor access clear
      bus_write(1'b0, 3'd3, 8'h03, 1'b0);
      bus_write(1'b0, 3'd0, 8'h41, 1'b1);
      bus_write(1'b0, 3'd2, 8'hC7, 1'b1);
      rd_chk("R4 core read addr0", 1'b0, 3'd0, 8'h5A);
      rd_chk("R4 core read addr1", 1'b0, 3'd1, 8'h5A);
      bus_write(1'b1, 3'd4, 8'h99, 1'b1);
      rd_chk("R4 core read B addr5", 1'b1, 3'd5, 8'hA5);
      bus_write(1'b0, 3'd3, 8'h83, 1'b0);
      rd_chk("R8 altfn kept through core write", 1'b0, 3'd2, 8'h09);
      rd_chk("R4 div lo kept through core write", 1'b0, 3'd0, 8'h01);

      // R1 select high
      bus_write(1'b0, 3'd3, 8'h55, 1'b0, 1'b0);
      rd_chk("R1 line unchanged with cs high", 1'b0, 3'd3, 8'h83);
      @(negedge clk);
      bus_rd_n = 1'b0; #1;
      chk("R1 no oe with cs high", {11'h0, bus_rdata_oe}, 12'h0);
      chk("R12 data zero with cs high", {4'h0, bus_rdata}, 12'h0);
      @(negedge clk);
      bus_rd_n = 1'b1;

      // R10 commit after strobe rise
      @(negedge clk);
      bus_chsel = 1'b0; bus_addr = 3'd3; bus_wdata = 8'h81; bus_cs_n = 1'b0;
      @(negedge clk);
      bus_wr_n = 1'b0;
      repeat (10) @(negedge clk);
      bus_rd_n = 1'b0; #1;
      chk("R10 old value while strobe low", {4'h0, bus_rdata}, 12'h083);
      @(negedge clk);
      bus_rd_n = 1'b1; bus_wr_n = 1'b1;
      repeat (2) @(negedge clk);
      bus_cs_n = 1'b1;
      repeat (5) @(negedge clk);
      rd_chk("R10 new value after rise", 1'b0, 3'd3, 8'h81);

      // R11 reset clears banks
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      rd_chk("R11 line A cleared", 1'b0, 3'd3, 8'h00);
      aux_out_n = 2'b01; #1;
      chk("R11 mf aux after reset", {10'h0, mf_out}, 12'h001);
      bus_write(1'b1, 3'd3, 8'h80, 1'b0);
      rd_chk("R11 B div cleared shows id", 1'b1, 3'd1, 8'h06);

      repeat (10) @(negedge clk);
      chk("R4 all expected core writes seen", 12'(exp_q.size()), 12'h0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule